// File: doc/BRIEF.md
# Register Alias Table Renamer

This block sits in the rename stage of an out-of-order core. It keeps one entry per architectural register naming the physical register that currently holds that register's value. Each cycle the front end may offer one instruction with two source register indices and an optional destination index. The block looks up both sources and returns their physical tags. When the instruction writes a destination, the block takes a fresh tag from an external free-list interface, reports the displaced mapping so that it can be reclaimed later, and installs the new tag in the table.

An instruction flagged as a zero idiom needs no allocation. Its destination is pointed at a reserved physical register that always reads as zero, and the free list is not touched. A separate restore port lets branch-recovery logic overwrite the whole table in a single cycle. A restore wins over any rename offered in the same cycle. The free list, execution, commit and the checkpoint storage live outside this block.

Top module: `rat_renamer`

## Requirements
- R1: After synchronous reset, architectural register i maps to physical register i for every i, so a lookup of index i returns tag i.
- R2: Each of the two source ports returns the table entry for its own architectural index, independently of the other port and in the same cycle.
- R3: Sources see the mapping in effect before the same instruction's destination write. For R1 = R1 + x, the source tag is the old tag of R1.
- R4: A fired instruction with a destination and no zero-idiom flag asserts fl_pop for that cycle, reports fl_tag on dst_tag, and from the next cycle the table maps its destination to that tag. fl_pop is never high without fl_valid.
- R5: A fired instruction with a destination reports the prior entry for that destination on old_tag with old_valid high.
- R6: A fired instruction with no destination does not pop the free list, reports old_valid low, and leaves the table unchanged.
- R7: When fl_valid is low, in_ready is low for an instruction that needs a fresh tag. An instruction with no destination, or a zero idiom, is still accepted.
- R8: A fired zero-idiom instruction with a destination maps that destination to the reserved zero tag (PHYS_REGS-1, that is 63 by default), reports that tag on dst_tag and does not pop the free list.
- R9: When restore_en is high, the whole table is loaded from restore_map in one cycle, with entry i at bits [i*6 +: 6]. In that cycle in_ready is low, nothing is popped and no rename takes effect.
- R10: Starting from R1→10, R2→11, R8→18, R9→19 with free tags 30, 31, 32 offered in order, the sequence load R1; R2 = R1 + 5; R1 = R9 * R8 yields destination tags 30, 31, 32. The second instruction's source is 30, and afterwards R1 maps to 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is offered |
| in_ready | output | 1 | The offered instruction is accepted this cycle |
| src0_arch | input | 4 | First source architectural index |
| src1_arch | input | 4 | Second source architectural index |
| dst_en | input | 1 | The instruction writes a destination |
| dst_arch | input | 4 | Destination architectural index |
| zero_idiom | input | 1 | The destination result is known to be zero |
| src0_tag | output | 6 | Physical tag for the first source |
| src1_tag | output | 6 | Physical tag for the second source |
| dst_tag | output | 6 | New physical tag for the destination |
| old_tag | output | 6 | Mapping displaced by the destination write |
| old_valid | output | 1 | old_tag is meaningful (fired with a destination) |
| fl_valid | input | 1 | The free list has a tag to give |
| fl_tag | input | 6 | Tag at the head of the free list |
| fl_pop | output | 1 | Consume the free-list head this cycle |
| restore_en | input | 1 | Load the whole table from restore_map |
| restore_map | input | 96 | Packed replacement table, 6 bits per entry |

## Verification
Directed sequences cover the worked three-instruction trace, a read of the register being written, which tells same-cycle ordering apart from write-through, and an empty free list offered with and without a destination. Zero idioms are checked for the fixed tag and the absent pop. Restores are presented together with a valid instruction, which tells restore priority apart from a rename leaking through. Random traffic then mixes all flags and random restore maps against a bench table model, so that aliasing between source and destination indices and between the two source ports shows up as a tag mismatch.

// File: rtl/rat_pkg.sv
package rat_pkg;
    localparam int ARCH_REGS_DEF = 16;
    localparam int PHYS_REGS_DEF = 64;
    localparam int NUM_SRC_DEF   = 2;

    // Write action taken on the alias table in a cycle
    typedef enum logic [1:0] {
        ACT_IDLE    = 2'd0,
        ACT_RENAME  = 2'd1,
        ACT_ZERO    = 2'd2,
        ACT_RESTORE = 2'd3
    } rat_act_e;

    function automatic bool_needs_alloc(input logic dst_en, input logic zero_idiom);
        return dst_en && !zero_idiom;
    endfunction
endpackage

// File: rtl/rat_table.sv
module rat_table
    import rat_pkg::*;
#(
    parameter int ARCH_REGS = ARCH_REGS_DEF,
    parameter int PHYS_REGS = PHYS_REGS_DEF,
    parameter int NUM_SRC   = NUM_SRC_DEF,
    localparam int AW = $clog2(ARCH_REGS),
    localparam int TW = $clog2(PHYS_REGS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_SRC*AW-1:0]    rd_addr,
    output logic [NUM_SRC*TW-1:0]    rd_tag,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  logic [TW-1:0]            wdata,
    output logic [TW-1:0]            wold,
    input  logic                     restore_en,
    input  logic [ARCH_REGS*TW-1:0]  restore_map
);
    logic [TW-1:0] map_q [ARCH_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ARCH_REGS; i++) map_q[i] <= TW'(i);
        end else if (restore_en) begin
            for (int i = 0; i < ARCH_REGS; i++) map_q[i] <= restore_map[i*TW +: TW];
        end else if (we) begin
            map_q[waddr] <= wdata;
        end
    end

    // One lookup per source operand; reads see the pre-write table
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_rd
        assign rd_tag[g*TW +: TW] = map_q[rd_addr[g*AW +: AW]];
    end

    assign wold = map_q[waddr];

    // R4: an installed mapping is visible on the next cycle
    p_write_lands_r4: assert property (@(posedge clk) disable iff (rst)
        (we && !restore_en) |=> (map_q[$past(waddr)] == $past(wdata)));

    // R9: restore loads every entry; spot-check first and last
    p_restore_first_r9: assert property (@(posedge clk) disable iff (rst)
        restore_en |=> (map_q[0] == $past(restore_map[TW-1:0])));
    p_restore_last_r9: assert property (@(posedge clk) disable iff (rst)
        restore_en |=> (map_q[ARCH_REGS-1] == $past(restore_map[ARCH_REGS*TW-1 -: TW])));
endmodule

// File: rtl/rat_alloc_ctrl.sv
module rat_alloc_ctrl
    import rat_pkg::*;
#(
    parameter int PHYS_REGS = PHYS_REGS_DEF,
    localparam int TW = $clog2(PHYS_REGS),
    localparam logic [TW-1:0] ZERO_TAG = TW'(PHYS_REGS - 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          dst_en,
    input  logic          zero_idiom,
    input  logic          fl_valid,
    input  logic [TW-1:0] fl_tag,
    input  logic          restore_en,
    output logic          in_ready,
    output logic          fire,
    output logic          fl_pop,
    output logic          tbl_we,
    output logic [TW-1:0] new_tag,
    output logic          old_valid
);
    rat_act_e act;
    logic     need_alloc;

    assign need_alloc = bool_needs_alloc(dst_en, zero_idiom);
    assign in_ready   = !restore_en && (!need_alloc || fl_valid);
    assign fire       = in_valid && in_ready;

    always_comb begin
        act = ACT_IDLE;
        if (restore_en)           act = ACT_RESTORE;
        else if (fire && dst_en)  act = zero_idiom ? ACT_ZERO : ACT_RENAME;
    end

    assign fl_pop    = (act == ACT_RENAME);
    assign tbl_we    = (act == ACT_RENAME) || (act == ACT_ZERO);
    assign new_tag   = (act == ACT_ZERO) ? ZERO_TAG : fl_tag;
    assign old_valid = fire && dst_en;

    // R4: never consume from an empty free list
    p_pop_has_tag_r4: assert property (@(posedge clk) disable iff (rst)
        fl_pop |-> fl_valid);
    // R8: zero idioms leave the free list alone
    p_zero_no_pop_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && zero_idiom) |-> !fl_pop);
    // R9: restore blocks renaming
    p_restore_stall_r9: assert property (@(posedge clk) disable iff (rst)
        restore_en |-> (!in_ready && !fl_pop && !tbl_we));
    // R6: no destination, no allocation
    p_no_dst_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !dst_en) |-> (!fl_pop && !old_valid));
    // R7: a needed tag that is missing stalls the front end
    p_empty_stall_r7: assert property (@(posedge clk) disable iff (rst)
        (dst_en && !zero_idiom && !fl_valid) |-> !in_ready);
endmodule

// File: rtl/rat_renamer.sv
module rat_renamer
    import rat_pkg::*;
#(
    parameter int ARCH_REGS = ARCH_REGS_DEF,
    parameter int PHYS_REGS = PHYS_REGS_DEF,
    localparam int AW = $clog2(ARCH_REGS),
    localparam int TW = $clog2(PHYS_REGS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [AW-1:0]           src0_arch,
    input  logic [AW-1:0]           src1_arch,
    input  logic                    dst_en,
    input  logic [AW-1:0]           dst_arch,
    input  logic                    zero_idiom,
    output logic [TW-1:0]           src0_tag,
    output logic [TW-1:0]           src1_tag,
    output logic [TW-1:0]           dst_tag,
    output logic [TW-1:0]           old_tag,
    output logic                    old_valid,
    input  logic                    fl_valid,
    input  logic [TW-1:0]           fl_tag,
    output logic                    fl_pop,
    input  logic                    restore_en,
    input  logic [ARCH_REGS*TW-1:0] restore_map
);
    localparam int NSRC = 2;

    logic [NSRC*AW-1:0] rd_addr;
    logic [NSRC*TW-1:0] rd_tag;
    logic               fire;
    logic               tbl_we;
    logic [TW-1:0]      new_tag;

    assign rd_addr  = {src1_arch, src0_arch};
    assign src0_tag = rd_tag[TW-1:0];
    assign src1_tag = rd_tag[2*TW-1:TW];
    assign dst_tag  = new_tag;

    rat_alloc_ctrl #(.PHYS_REGS(PHYS_REGS)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .dst_en     (dst_en),
        .zero_idiom (zero_idiom),
        .fl_valid   (fl_valid),
        .fl_tag     (fl_tag),
        .restore_en (restore_en),
        .in_ready   (in_ready),
        .fire       (fire),
        .fl_pop     (fl_pop),
        .tbl_we     (tbl_we),
        .new_tag    (new_tag),
        .old_valid  (old_valid)
    );

    rat_table #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS), .NUM_SRC(NSRC)) u_table (
        .clk         (clk),
        .rst         (rst),
        .rd_addr     (rd_addr),
        .rd_tag      (rd_tag),
        .we          (tbl_we),
        .waddr       (dst_arch),
        .wdata       (new_tag),
        .wold        (old_tag),
        .restore_en  (restore_en),
        .restore_map (restore_map)
    );

    // R3: a source naming the destination gets the displaced tag
    p_src_pre_write_r3: assert property (@(posedge clk) disable iff (rst)
        (fire && dst_en && src0_arch == dst_arch) |-> (src0_tag == old_tag));
    // R4: the popped tag is the one reported as the destination
    p_pop_tag_r4: assert property (@(posedge clk) disable iff (rst)
        fl_pop |-> (dst_tag == fl_tag && fire));
    // R6: a fire without destination leaves a later lookup unchanged
    p_no_dst_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (fire && !dst_en && !restore_en) |=> $stable(old_tag) || $changed(dst_arch));
endmodule

// File: tb/rat_renamer_bench.sv
module rat_renamer_bench;
    localparam int A = 16;
    localparam int T = 6;
    localparam logic [T-1:0] ZT = 6'd63;

    logic clk = 0, rst = 1;
    logic in_valid = 0, in_ready;
    logic [3:0] src0_arch = 0, src1_arch = 0, dst_arch = 0;
    logic dst_en = 0, zero_idiom = 0;
    logic [T-1:0] src0_tag, src1_tag, dst_tag, old_tag, fl_tag = 0;
    logic old_valid, fl_valid = 0, fl_pop, restore_en = 0;
    logic [A*T-1:0] restore_map = '0;

    int checks = 0, errors = 0, cycles = 0;
    bit done = 0;
    logic [T-1:0] model [A];

    always #10 clk = ~clk;

    rat_renamer u_rat_renamer (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit exp_ready(bit rs, bit de, bit z, bit flv);
        return !rs && (!(de && !z) || flv);
    endfunction

    // One cycle: drive at negedge, check combinational outputs, update model
    task automatic step(bit v, logic [3:0] s0, logic [3:0] s1, bit de,
                        logic [3:0] d, bit z, bit flv, logic [T-1:0] flt,
                        bit rs, logic [A*T-1:0] rmap);
        bit rdy, f;
        @(negedge clk);
        in_valid = v; src0_arch = s0; src1_arch = s1; dst_en = de;
        dst_arch = d; zero_idiom = z; fl_valid = flv; fl_tag = flt;
        restore_en = rs; restore_map = rmap;
        #1;
        rdy = exp_ready(rs, de, z, flv);
        f = v && rdy;
        chk(rs ? "R9 ready" : "R7 ready", in_ready, rdy);
        chk(rs ? "R9 pop" : (z ? "R8 pop" : (de ? "R4 pop" : "R6 pop")),
            fl_pop, f && de && !z);
        if (f) begin
            chk("R2 src0", src0_tag, model[s0]);
            chk(s1 == d ? "R3 src1" : "R2 src1", src1_tag, model[s1]);
            chk(de ? "R5 old_valid" : "R6 old_valid", old_valid, de);
            if (de) begin
                chk("R5 old_tag", old_tag, model[d]);
                chk(z ? "R8 dst_tag" : "R4 dst_tag", dst_tag, z ? ZT : flt);
            end
        end
        if (rs) for (int i = 0; i < A; i++) model[i] = rmap[i*T +: T];
        else if (f && de) model[d] = z ? ZT : flt;
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, '0);
    endtask

    task automatic check_map(input string req);
        for (int i = 0; i < A; i++) begin
            @(negedge clk);
            in_valid = 0; restore_en = 0; src0_arch = 4'(i); src1_arch = 4'(A-1-i);
            #1;
            chk(req, src0_tag, model[i]);
            chk(req, src1_tag, model[A-1-i]);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                errors++; checks++;
                $display("FAIL watchdog: actual %0d expected 0", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [A*T-1:0] m;
        void'($urandom(1234));
        for (int i = 0; i < A; i++) model[i] = T'(i);
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        check_map("R1 reset map");

        // R10 worked trace, preceded by a restore that races a valid instruction
        m = '0;
        for (int i = 0; i < A; i++) m[i*T +: T] = T'(i);
        m[1*T +: T] = 6'd10; m[2*T +: T] = 6'd11; m[8*T +: T] = 6'd18; m[9*T +: T] = 6'd19;
        step(1, 3, 4, 1, 5, 0, 1, 6'd40, 1, m);          // R9 priority
        check_map("R9 restore");
        step(1, 0, 0, 1, 1, 0, 1, 6'd30, 0, '0);
        chk("R10 R1 tag", dst_tag, 30);
        step(1, 1, 1, 1, 2, 0, 1, 6'd31, 0, '0);
        chk("R10 src", src0_tag, 30);
        chk("R10 R2 tag", dst_tag, 31);
        step(1, 9, 8, 1, 1, 0, 1, 6'd32, 0, '0);
        chk("R10 srcs", {26'd0, src0_tag, src1_tag}, {6'd19, 6'd18});
        idle();
        check_map("R10 final map");
        chk("R10 R1 final", int'(model[1]), 32);

        // R3: read and write the same register
        step(1, 4, 4, 1, 4, 0, 1, 6'd50, 0, '0);
        chk("R3 src sees old", src0_tag, 4);
        // R7: empty free list, needing a tag then not needing one
        step(1, 2, 3, 1, 6, 0, 0, 6'd51, 0, '0);
        step(1, 2, 3, 0, 6, 0, 0, 6'd51, 0, '0);
        step(1, 2, 3, 1, 7, 1, 0, 6'd51, 0, '0);        // R8 with empty list
        idle();
        check_map("R6 R7 R8 map");

        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            bit rs = ($urandom % 40) == 0;
            if (rs) for (int i = 0; i < A; i++) m[i*T +: T] = T'($urandom % 64);
            step($urandom % 4 != 0, 4'($urandom), 4'($urandom), $urandom % 3 != 0,
                 4'($urandom), $urandom % 8 == 0, $urandom % 4 != 0,
                 T'($urandom % 63), rs, m);
        end
        idle();
        check_map("R4 random map");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule